// File: doc/BRIEF.md
# Write-Once Snooping Coherence Controller

This block keeps the coherence state of every line of a small direct-mapped cache that shares a bus with other caches. Each cycle it takes at most one local processor request (read or write) or one snooped bus transaction (read or write) from another master. It looks up the line's tag and state, decides the bus action, and updates the line. The bus actions are: a write-through to memory, an invalidate broadcast, a line fetch from memory, or a cache-to-cache supply with memory inhibited. When a dirty line is evicted, a separate write-back request is raised with the victim's address.

The first processor write to a clean line goes through to memory. Later writes to that line stay local. A static `own_mode` input picks between two variants. In the plain write-once variant, a snooped read of a dirty line is served by this cache and the line returns to clean. In the ownership variant, dirty data keeps an owner: the modified state splits into a sole-copy form and a shared-copy form, and only the owner ever writes the line back. The data array, bus arbitration and the other caches sit outside the block.

Line states are encoded as 0 Invalid, 1 Clean (valid, never written), 2 Written-once, 3 Dirty (written more than once, or in ownership mode modified with no other copy), and 4 Dirty-shared (ownership mode only, modified with other copies present). Bus action codes are 0 none, 1 write-through, 2 invalidate, 3 fetch, 4 supply. Addresses are `{tag, index}`, with the index in the low `IDX_W` bits. All action outputs are registered and appear in the cycle after the request edge. `line_state` is a combinational view of the line chosen by `line_sel`.

Top module: `wonce_coh_ctrl`

## Requirements
- R1: After reset every line reads state 0, and `cpu_done`, `cpu_hit`, `act_op`, `mem_inhibit` and `wb_valid` are 0.
- R2: A processor read that misses gives `act_op`=3 with `act_addr` equal to the request address, and installs the line in state 1 with the new tag.
- R3: A processor read that hits gives `cpu_hit`=1 and `act_op`=0, and leaves the line state unchanged.
- R4: A processor write that hits a state-1 line gives `act_op`=1 and moves the line to state 2.
- R5: A processor write that hits a state-2 line gives `act_op`=0 and moves the line to state 3. A write that hits state 3 gives `act_op`=0 and the line stays in state 3.
- R6: A snooped write that hits a line moves it to state 0, with `act_op`=0 and `mem_inhibit`=0.
- R7: A snooped read that hits a state-1 or state-2 line gives `act_op`=0 and `mem_inhibit`=0, and leaves the line in state 1.
- R8: With `own_mode`=0, a snooped read that hits a state-3 line gives `act_op`=4 and `mem_inhibit`=1, with `act_addr` equal to the snoop address, and moves the line to state 1. State 4 never appears in this mode.
- R9: With `own_mode`=1, a snooped read that hits a state-3 or state-4 line gives `act_op`=4 and `mem_inhibit`=1, and moves the line to state 4.
- R10: With `own_mode`=1, a processor write that hits a state-4 line gives `act_op`=2 and moves the line to state 3.
- R11: A processor write that misses allocates the line in state 2 with the new tag and gives `act_op`=1.
- R12: On any processor miss whose victim is in state 3 or 4, the block gives `wb_valid`=1 and `wb_addr`={victim tag, index}. On a miss whose victim is in state 0, 1 or 2, `wb_valid` stays 0.
- R13: A snoop takes the cycle. A processor request presented together with `snp_valid` is not accepted: `cpu_done`=0 and the processor's line is untouched. A snoop that misses gives no action and changes no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_mode | input | 1 | 1 selects the ownership variant; change only under reset |
| cpu_req | input | 1 | Processor request present |
| cpu_wr | input | 1 | Processor request is a write |
| cpu_addr | input | TAG_W+IDX_W | Processor address {tag, index} |
| snp_valid | input | 1 | Snooped bus transaction from another master |
| snp_wr | input | 1 | Snooped transaction is a write or invalidate |
| snp_addr | input | TAG_W+IDX_W | Snooped address {tag, index} |
| line_sel | input | IDX_W | Line shown on line_state |
| cpu_done | output | 1 | Processor request was accepted last cycle |
| cpu_hit | output | 1 | Accepted request hit |
| act_op | output | 3 | Bus action code |
| act_addr | output | TAG_W+IDX_W | Address of the bus action |
| mem_inhibit | output | 1 | Memory must not answer; this cache drives the data |
| wb_valid | output | 1 | Evicted dirty line must be written back |
| wb_addr | output | TAG_W+IDX_W | Address of the evicted line |
| line_state | output | 3 | State of the line picked by line_sel |

## Verification
Directed sequences walk single lines through each transition. Examples are read miss, repeated writes, a snoop read of a once-written line against one of a dirty line, a snoop write, a colliding snoop and processor request, and an eviction of a dirty victim against a clean one. Each of these is run in both modes, so a mix-up between the plain reflection to clean and the retained shared ownership shows up at once. Constrained-random traffic then drives four hot indices and four tags, so that hits, conflict misses and snoop hits are all frequent. Every cycle is compared with a reference state table kept in the bench. The per-line state readout catches a wrong next state even when the bus action is correct.

// File: rtl/wo_coh_pkg.sv
package wo_coh_pkg;

  typedef enum logic [2:0] {
    LS_INV      = 3'd0,
    LS_CLEAN    = 3'd1,
    LS_ONCE     = 3'd2,
    LS_DIRTY    = 3'd3,
    LS_DIRTY_SH = 3'd4
  } line_st_e;

  typedef enum logic [2:0] {
    BO_NONE   = 3'd0,
    BO_WRTHRU = 3'd1,
    BO_INVAL  = 3'd2,
    BO_FETCH  = 3'd3,
    BO_SUPPLY = 3'd4
  } bus_op_e;

  typedef struct packed {
    line_st_e nst;
    bus_op_e  op;
    logic     inhibit;
  } decision_t;

  function automatic logic is_dirty(line_st_e s);
    return (s == LS_DIRTY) || (s == LS_DIRTY_SH);
  endfunction

  // Local processor access: next state and bus action.
  function automatic decision_t cpu_decide(logic own, logic hit, logic wr, line_st_e s);
    decision_t d;
    d.inhibit = 1'b0;
    d.nst     = s;
    d.op      = BO_NONE;
    if (!hit) begin
      d.nst = wr ? LS_ONCE : LS_CLEAN;
      d.op  = wr ? BO_WRTHRU : BO_FETCH;
    end else if (wr) begin
      unique case (s)
        LS_CLEAN:    begin d.nst = LS_ONCE;  d.op = BO_WRTHRU; end
        LS_ONCE:     begin d.nst = LS_DIRTY; d.op = BO_NONE;   end
        LS_DIRTY:    begin d.nst = LS_DIRTY; d.op = BO_NONE;   end
        LS_DIRTY_SH: begin d.nst = LS_DIRTY; d.op = own ? BO_INVAL : BO_INVAL; end
        default:     begin d.nst = s;        d.op = BO_NONE;   end
      endcase
    end
    return d;
  endfunction

  // Snooped transaction that hit this cache.
  function automatic decision_t snp_decide(logic own, logic wr, line_st_e s);
    decision_t d;
    d.inhibit = 1'b0;
    d.nst     = s;
    d.op      = BO_NONE;
    if (wr) begin
      d.nst = LS_INV;
    end else begin
      unique case (s)
        LS_CLEAN, LS_ONCE: d.nst = LS_CLEAN;
        LS_DIRTY, LS_DIRTY_SH: begin
          d.nst     = own ? LS_DIRTY_SH : LS_CLEAN;
          d.op      = BO_SUPPLY;
          d.inhibit = 1'b1;
        end
        default: d.nst = s;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/wo_line_store.sv
module wo_line_store
  import wo_coh_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  line_st_e         wst,
  input  logic [TAG_W-1:0] wtag,
  output line_st_e         st_q  [LINES],
  output logic [TAG_W-1:0] tag_q [LINES]
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e         st_r;
    logic [TAG_W-1:0] tag_r;
    logic             sel;

    assign sel = we && (widx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r  <= LS_INV;
        tag_r <= '0;
      end else if (sel) begin
        st_r  <= wst;
        tag_r <= wtag;
      end
    end

    assign st_q[g]  = st_r;
    assign tag_q[g] = tag_r;
  end

endmodule

// File: rtl/wo_lookup.sv
module wo_lookup
  import wo_coh_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(LINES)
) (
  input  line_st_e         st_q  [LINES],
  input  logic [TAG_W-1:0] tag_q [LINES],
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  output line_st_e         st,
  output logic [TAG_W-1:0] stored_tag,
  output logic             hit
);

  assign st         = st_q[idx];
  assign stored_tag = tag_q[idx];
  assign hit        = (st != LS_INV) && (stored_tag == tag);

endmodule

// File: rtl/wonce_coh_ctrl.sv
module wonce_coh_ctrl
  import wo_coh_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TAG_W = 6,
  localparam int IDX_W  = $clog2(LINES),
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              own_mode,
  input  logic              cpu_req,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              snp_valid,
  input  logic              snp_wr,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [IDX_W-1:0]  line_sel,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic [2:0]        act_op,
  output logic [ADDR_W-1:0] act_addr,
  output logic              mem_inhibit,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [2:0]        line_state
);

  line_st_e         st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  logic [IDX_W-1:0] c_idx, s_idx;
  logic [TAG_W-1:0] c_tag, s_tag, c_old_tag, s_old_tag;
  line_st_e         c_st, s_st;
  logic             c_hit, s_hit;

  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];

  wo_lookup #(.LINES(LINES), .TAG_W(TAG_W)) u_cpu_look (
    .st_q(st_q), .tag_q(tag_q), .idx(c_idx), .tag(c_tag),
    .st(c_st), .stored_tag(c_old_tag), .hit(c_hit)
  );

  wo_lookup #(.LINES(LINES), .TAG_W(TAG_W)) u_snp_look (
    .st_q(st_q), .tag_q(tag_q), .idx(s_idx), .tag(s_tag),
    .st(s_st), .stored_tag(s_old_tag), .hit(s_hit)
  );

  // Named internal events (also observed by the checker).
  logic cpu_go, snp_act;
  logic ev_rd_miss, ev_first_wr, ev_sh_wr, ev_snp_wr_hit, ev_snp_rd_dirty, ev_evict_dirty;

  assign cpu_go          = cpu_req && !snp_valid;
  assign snp_act         = snp_valid && s_hit;
  assign ev_rd_miss      = cpu_go && !cpu_wr && !c_hit;
  assign ev_first_wr     = cpu_go && cpu_wr && c_hit && (c_st == LS_CLEAN);
  assign ev_sh_wr        = cpu_go && cpu_wr && c_hit && (c_st == LS_DIRTY_SH);
  assign ev_snp_wr_hit   = snp_act && snp_wr;
  assign ev_snp_rd_dirty = snp_act && !snp_wr && is_dirty(s_st);
  assign ev_evict_dirty  = cpu_go && !c_hit && is_dirty(c_st);

  decision_t cd, sd;
  assign cd = cpu_decide(own_mode, c_hit, cpu_wr, c_st);
  assign sd = snp_decide(own_mode, snp_wr, s_st);

  logic             w_en;
  logic [IDX_W-1:0] w_idx;
  line_st_e         w_st;
  logic [TAG_W-1:0] w_tag;

  always_comb begin
    w_en  = snp_act || cpu_go;
    w_idx = c_idx;
    w_st  = cd.nst;
    w_tag = c_tag;
    if (snp_act) begin
      w_idx = s_idx;
      w_st  = sd.nst;
      w_tag = s_old_tag;
    end
  end

  wo_line_store #(.LINES(LINES), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(w_en), .widx(w_idx), .wst(w_st), .wtag(w_tag),
    .st_q(st_q), .tag_q(tag_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_done    <= 1'b0;
      cpu_hit     <= 1'b0;
      act_op      <= 3'(BO_NONE);
      act_addr    <= '0;
      mem_inhibit <= 1'b0;
      wb_valid    <= 1'b0;
      wb_addr     <= '0;
    end else begin
      cpu_done    <= cpu_go;
      cpu_hit     <= cpu_go && c_hit;
      mem_inhibit <= snp_act && sd.inhibit;
      wb_valid    <= ev_evict_dirty;
      wb_addr     <= {c_old_tag, c_idx};
      if (snp_act) begin
        act_op   <= 3'(sd.op);
        act_addr <= snp_addr;
      end else if (cpu_go) begin
        act_op   <= 3'(cd.op);
        act_addr <= cpu_addr;
      end else begin
        act_op   <= 3'(BO_NONE);
        act_addr <= '0;
      end
    end
  end

  assign line_state = 3'(st_q[line_sel]);

endmodule

// File: rtl/wo_coh_checker.sv
module wo_coh_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       own_mode,
  input logic       snp_valid,
  input logic       snp_wr,
  input logic       cpu_done,
  input logic [2:0] act_op,
  input logic       mem_inhibit,
  input logic       wb_valid,
  input logic [2:0] line_state,
  input logic       ev_rd_miss,
  input logic       ev_first_wr,
  input logic       ev_sh_wr,
  input logic       ev_snp_wr_hit,
  input logic       ev_snp_rd_dirty,
  input logic       ev_evict_dirty
);

  assert_fetch_on_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_miss |=> (act_op == 3'd3) && cpu_done);

  assert_first_write_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_first_wr |=> (act_op == 3'd1));

  assert_snoop_write_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_snp_wr_hit |=> (act_op == 3'd0) && !mem_inhibit);

  assert_dirty_supply_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_snp_rd_dirty |=> mem_inhibit && (act_op == 3'd4));

  assert_inhibit_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_inhibit |-> $past(snp_valid && !snp_wr));

  assert_no_shared_dirty_basic_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !own_mode |-> (line_state != 3'd4));

  assert_shared_write_inval_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sh_wr |=> (act_op == 3'd2));

  assert_writeback_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_evict_dirty |=> wb_valid);

  assert_snoop_blocks_cpu_R13: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> !cpu_done);

endmodule

bind wonce_coh_ctrl wo_coh_checker u_chk (
  .clk(clk), .rst_n(rst_n), .own_mode(own_mode), .snp_valid(snp_valid), .snp_wr(snp_wr),
  .cpu_done(cpu_done), .act_op(act_op), .mem_inhibit(mem_inhibit), .wb_valid(wb_valid),
  .line_state(line_state), .ev_rd_miss(ev_rd_miss), .ev_first_wr(ev_first_wr),
  .ev_sh_wr(ev_sh_wr), .ev_snp_wr_hit(ev_snp_wr_hit), .ev_snp_rd_dirty(ev_snp_rd_dirty),
  .ev_evict_dirty(ev_evict_dirty)
);

// File: tb/tb_wonce_coh_ctrl.sv
module tb_wonce_coh_ctrl;
  localparam int LINES = 16;
  localparam int TAG_W = 6;
  localparam int IDX_W = 4;
  localparam int ADDR_W = TAG_W + IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic own_mode = 1'b0;
  logic cpu_req = 1'b0, cpu_wr = 1'b0, snp_valid = 1'b0, snp_wr = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0, snp_addr = '0;
  logic [IDX_W-1:0] line_sel = '0;
  logic cpu_done, cpu_hit, mem_inhibit, wb_valid;
  logic [2:0] act_op, line_state;
  logic [ADDR_W-1:0] act_addr, wb_addr;

  always #5 clk = ~clk;

  wonce_coh_ctrl #(.LINES(LINES), .TAG_W(TAG_W)) dut (
    .clk(clk), .rst_n(rst_n), .own_mode(own_mode), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .snp_valid(snp_valid), .snp_wr(snp_wr), .snp_addr(snp_addr),
    .line_sel(line_sel), .cpu_done(cpu_done), .cpu_hit(cpu_hit), .act_op(act_op),
    .act_addr(act_addr), .mem_inhibit(mem_inhibit), .wb_valid(wb_valid), .wb_addr(wb_addr),
    .line_state(line_state)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  int m_st  [LINES];
  int m_tag [LINES];

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int mk(int tag, int idx);
    return tag * LINES + idx;
  endfunction

  function automatic bit dirty(int s);
    return (s == 3) || (s == 4);
  endfunction

  task automatic model_clear();
    for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tag[i] = 0; end
  endtask

  task automatic do_reset(bit mode);
    rst_n = 1'b0; own_mode = mode;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    @(negedge clk);
  endtask

  // One cycle of stimulus; expected results from the state table.
  task automatic step(bit c_req, bit c_wr, int c_a, bit s_v, bit s_w, int s_a, string req);
    int ci = c_a % LINES, ct = c_a / LINES, si = s_a % LINES, st = s_a / LINES;
    int e_op = 0, e_inh = 0, e_done = 0, e_hit = 0, e_wb = 0, e_wba = 0, e_addr = 0;
    bit s_hit = s_v && (m_st[si] != 0) && (m_tag[si] == st);
    if (s_hit) begin
      e_addr = s_a;
      if (s_w) m_st[si] = 0;
      else if (m_st[si] == 1 || m_st[si] == 2) m_st[si] = 1;
      else begin
        e_op = 4; e_inh = 1;
        m_st[si] = own_mode ? 4 : 1;
      end
    end else if (c_req && !s_v) begin
      bit h = (m_st[ci] != 0) && (m_tag[ci] == ct);
      e_done = 1; e_hit = h; e_addr = c_a;
      if (!h) begin
        if (dirty(m_st[ci])) begin e_wb = 1; e_wba = mk(m_tag[ci], ci); end
        e_op = c_wr ? 1 : 3;
        m_st[ci] = c_wr ? 2 : 1;
        m_tag[ci] = ct;
      end else if (c_wr) begin
        case (m_st[ci])
          1: begin e_op = 1; m_st[ci] = 2; end
          4: begin e_op = 2; m_st[ci] = 3; end
          default: m_st[ci] = 3;
        endcase
      end
    end
    cpu_req = c_req; cpu_wr = c_wr; cpu_addr = ADDR_W'(c_a);
    snp_valid = s_v; snp_wr = s_w; snp_addr = ADDR_W'(s_a);
    @(posedge clk);
    #2;
    cpu_req = 0; snp_valid = 0;
    line_sel = IDX_W'(ci);
    #1;
    check(req, "cpu_done", int'(cpu_done), e_done);
    check(req, "cpu_hit", int'(cpu_hit), e_hit);
    check(req, "act_op", int'(act_op), e_op);
    if (e_op != 0) check(req, "act_addr", int'(act_addr), e_addr);
    check(req, "mem_inhibit", int'(mem_inhibit), e_inh);
    check(req, "wb_valid", int'(wb_valid), e_wb);
    if (e_wb) check(req, "wb_addr", int'(wb_addr), e_wba);
    check(req, "cpu line state", int'(line_state), m_st[ci]);
    line_sel = IDX_W'(si);
    #1;
    check(req, "snoop line state", int'(line_state), m_st[si]);
    @(negedge clk);
  endtask

  task automatic cpu(bit w, int a, string req);  step(1, w, a, 0, 0, 0, req); endtask
  task automatic snp(bit w, int a, string req);  step(0, 0, 0, 1, w, a, req); endtask

  task automatic state_is(int idx, int exp, string req);
    line_sel = IDX_W'(idx);
    #1;
    check(req, "literal state", int'(line_state), exp);
  endtask

  task automatic random_run(int n);
    for (int k = 0; k < n; k++) begin
      int kind = $urandom_range(0, 9);
      int ca = mk($urandom_range(0, 3), $urandom_range(0, 3));
      int sa = mk($urandom_range(0, 3), $urandom_range(0, 3));
      bit w = $urandom_range(0, 1) == 1;
      if (kind < 6)      step(1, w, ca, 0, 0, 0, own_mode ? "R10" : "R5");
      else if (kind < 9) step(0, 0, 0, 1, w, sa, own_mode ? "R9" : "R8");
      else               step(1, w, ca, 1, $urandom_range(0, 1) == 1, sa, "R13");
    end
  endtask

  initial begin
    void'($urandom(32'h00c0ffee));
    do_reset(0);
    // R1: reset state of every line and of the outputs
    for (int i = 0; i < LINES; i++) state_is(i, 0, "R1");
    check("R1", "act_op", int'(act_op), 0);
    check("R1", "outputs idle", int'({cpu_done, cpu_hit, mem_inhibit, wb_valid}), 0);

    // Plain write-once variant
    cpu(0, mk(1, 2), "R2");  state_is(2, 1, "R2");
    cpu(0, mk(1, 2), "R3");
    cpu(1, mk(1, 2), "R4");  state_is(2, 2, "R4");
    cpu(1, mk(1, 2), "R5");  state_is(2, 3, "R5");
    cpu(1, mk(1, 2), "R5");
    snp(0, mk(1, 2), "R8");  state_is(2, 1, "R8");
    cpu(1, mk(1, 2), "R4");
    snp(0, mk(1, 2), "R7");  state_is(2, 1, "R7");
    snp(1, mk(1, 2), "R6");  state_is(2, 0, "R6");
    snp(0, mk(5, 7), "R13"); state_is(7, 0, "R13");
    cpu(0, mk(2, 3), "R2");
    step(1, 1, mk(2, 3), 1, 0, mk(9, 9), "R13"); state_is(3, 1, "R13");
    cpu(1, mk(2, 3), "R4");  cpu(1, mk(2, 3), "R5");
    cpu(0, mk(3, 3), "R12"); state_is(3, 1, "R12");
    cpu(0, mk(4, 3), "R12");
    cpu(1, mk(6, 4), "R11"); state_is(4, 2, "R11");
    cpu(1, mk(7, 4), "R12");
    random_run(600);

    // Ownership variant
    do_reset(1);
    cpu(0, mk(1, 5), "R2"); cpu(1, mk(1, 5), "R4"); cpu(1, mk(1, 5), "R5");
    snp(0, mk(1, 5), "R9"); state_is(5, 4, "R9");
    snp(0, mk(1, 5), "R9");
    cpu(1, mk(1, 5), "R10"); state_is(5, 3, "R10");
    snp(0, mk(1, 5), "R9");
    cpu(0, mk(2, 5), "R12");
    random_run(600);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #500us;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule